// File: doc/BRIEF.md
# GPIO Grouped External Interrupt Controller

This block gathers interrupt requests from a set of GPIO pin banks. Every pin runs its own trigger detector, which can be set for a level or an edge. When the trigger fires, the pin's pending bit is set and stays set until software acknowledges it. A per-pin mask decides whether a pending pin reaches the single combined interrupt line. The mask does not stop the pending bit from being recorded.

Software reaches the block through a simple synchronous bus with word addresses. Each bank has three words: trigger configuration, mask and pending. One service word, shared by all banks, names the bank and pin that should be handled next. A handler reads the service word and jumps straight to that source, without scanning every pending word. Pins are numbered one after another across the banks: pin `p` of bank `b` is input bit `b*PINS + p`.

Top module: `gint_ctrl`

## Requirements
- R1: Each pin has a 3-bit trigger field at bits [3p+2:3p] of its bank's configuration word. The codes are 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge and 4 = both edges. Codes 5, 6 and 7 disable the pin, so it never sets its pending bit.
- R2: Word address bits [5:4] select the region: 0 = configuration, 1 = mask, 2 = pending, 3 = service. Bits [3:0] give the bank index. A bank index at or above NUM_BANKS reads as zero.
- R3: A mask bit of 1 keeps its pin out of both the interrupt output and the service word. The pending bit is still recorded.
- R4: Writing a pending word clears every bit written as 1. Bits written as 0 are unchanged. Pending bits never clear in any other way.
- R5: An edge trigger sets its pending bit at the third rising clock edge after the input change, because the input passes two synchronizer stages first. The bit stays set until it is cleared, even while the input holds its new value.
- R6: A level trigger sets its pending bit on every cycle in which the level is active. A clear therefore has no lasting effect while the level persists. When a set and a clear fall in the same cycle, the set wins.
- R7: The service word holds the one-based bank number in bits [15:8] and the pin number in bits [7:0]. It reads as 0 when no unmasked pin is pending.
- R8: The service word selects the lowest-numbered bank that has an unmasked pending pin. Within that bank it selects the lowest pin.
- R9: `irq_out` is high exactly when at least one pending bit has its mask bit clear.
- R10: After reset every trigger field holds 7 (disabled), every mask bit is 1 and every pending bit is 0.
- R11: Read data appears on `bus_rdata` in the cycle after the read and is zero in any cycle that follows no read. Writes to the service word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_BANKS*PINS | Asynchronous pin levels; bank b pin p at bit b*PINS+p |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Some properties hold on every cycle, and the assertions check these. The interrupt line must agree with whether the service word is non-zero. The service fields must stay within range, and the selected pin must really be both pending and unmasked. A fully masked controller never raises the line. Pending bits drop only after a write, and the read port is zero when idle. Other behaviours can only be shown by the bench's scenarios: the exact latency through the synchronizer, the meaning of each trigger code, level re-assertion after a clear, and the bank-first, pin-second ordering of the service selection.

// File: rtl/gint_pkg.sv
package gint_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int TRIG_W      = 3;
    localparam int BANK_IDX_W  = 4;
    localparam int SVC_FIELD_W = 8;

    typedef enum logic [1:0] {
        RGN_CFG  = 2'd0,
        RGN_MASK = 2'd1,
        RGN_PEND = 2'd2,
        RGN_SVC  = 2'd3
    } region_e;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_LO = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_FALL   = 3'd2,
        TRIG_RISE   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    typedef struct packed {
        region_e               rgn;
        logic [BANK_IDX_W-1:0] bank;
    } addr_t;

    typedef struct packed {
        logic [SVC_FIELD_W-1:0] group;
        logic [SVC_FIELD_W-1:0] pin;
    } svc_t;

    // One pin's trigger decision from its current and previous synchronized level.
    function automatic logic trig_hit(input logic [TRIG_W-1:0] code,
                                      input logic cur,
                                      input logic prev);
        logic hit;
        case (code)
            TRIG_LVL_LO: hit = !cur;
            TRIG_LVL_HI: hit = cur;
            TRIG_FALL:   hit = prev && !cur;
            TRIG_RISE:   hit = !prev && cur;
            TRIG_BOTH:   hit = prev ^ cur;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gint_sync.sv
module gint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gint_bank.sv
module gint_bank
    import gint_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PINS-1:0]        pin_sync,
    input  logic                   cfg_we,
    input  logic                   mask_we,
    input  logic                   pend_we,
    input  logic [PINS*TRIG_W-1:0] wr_cfg,
    input  logic [PINS-1:0]        wr_bits,
    output logic [PINS*TRIG_W-1:0] cfg_q,
    output logic [PINS-1:0]        mask_q,
    output logic [PINS-1:0]        pend_q
);

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] hit;
    logic [PINS-1:0] clr;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign hit[p] = trig_hit(cfg_q[p*TRIG_W +: TRIG_W], pin_sync[p], prev_q[p]);
    end

    assign clr = pend_we ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '1;
            mask_q <= '1;
            pend_q <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_sync;
            pend_q <= hit | (pend_q & ~clr);
            if (cfg_we) begin
                cfg_q <= wr_cfg;
            end
            if (mask_we) begin
                mask_q <= wr_bits;
            end
        end
    end

endmodule

// File: rtl/gint_service.sv
module gint_service
    import gint_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 8
) (
    input  logic [NUM_BANKS*PINS-1:0] eff,
    output svc_t                      svc
);

    logic found;

    always_comb begin
        found = 1'b0;
        svc   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int p = 0; p < PINS; p++) begin
                if (!found && eff[b*PINS + p]) begin
                    found     = 1'b1;
                    svc.group = SVC_FIELD_W'(b + 1);
                    svc.pin   = SVC_FIELD_W'(p);
                end
            end
        end
    end

endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl
    import gint_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_BANKS*PINS-1:0] pin_in,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      irq_out
);

    localparam int TOTAL = NUM_BANKS * PINS;
    localparam int CFG_W = PINS * TRIG_W;

    logic [TOTAL-1:0]   pin_sync;
    logic [TOTAL-1:0]   pend_all;
    logic [TOTAL-1:0]   mask_all;
    logic [TOTAL-1:0]   eff;
    logic [CFG_W-1:0]   cfg_words  [NUM_BANKS];
    logic [PINS-1:0]    mask_words [NUM_BANKS];
    logic [PINS-1:0]    pend_words [NUM_BANKS];
    addr_t              acc;
    logic               wr_en;
    logic               rd_en;
    svc_t               svc;
    logic [SVC_FIELD_W-1:0] svc_group;
    logic [SVC_FIELD_W-1:0] svc_pin;
    logic [DATA_W-1:0]  rd_next;
    logic               wdata_unused;

    assign acc          = addr_t'(bus_addr);
    assign wr_en        = bus_sel && bus_wr;
    assign rd_en        = bus_sel && !bus_wr;
    assign wdata_unused = ^bus_wdata;

    gint_sync #(.WIDTH(TOTAL)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel_bank;
        assign sel_bank = wr_en && (acc.bank == BANK_IDX_W'(b));

        gint_bank #(.PINS(PINS)) bank_i (
            .clk      (clk),
            .rst      (rst),
            .pin_sync (pin_sync[b*PINS +: PINS]),
            .cfg_we   (sel_bank && acc.rgn == RGN_CFG),
            .mask_we  (sel_bank && acc.rgn == RGN_MASK),
            .pend_we  (sel_bank && acc.rgn == RGN_PEND),
            .wr_cfg   (bus_wdata[CFG_W-1:0]),
            .wr_bits  (bus_wdata[PINS-1:0]),
            .cfg_q    (cfg_words[b]),
            .mask_q   (mask_words[b]),
            .pend_q   (pend_words[b])
        );

        assign pend_all[b*PINS +: PINS] = pend_words[b];
        assign mask_all[b*PINS +: PINS] = mask_words[b];
    end

    assign eff     = pend_all & ~mask_all;
    assign irq_out = |eff;

    gint_service #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) service_i (
        .eff (eff),
        .svc (svc)
    );

    assign svc_group = svc.group;
    assign svc_pin   = svc.pin;

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            case (acc.rgn)
                RGN_CFG: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (acc.bank == BANK_IDX_W'(b)) rd_next = DATA_W'(cfg_words[b]);
                    end
                end
                RGN_MASK: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (acc.bank == BANK_IDX_W'(b)) rd_next = DATA_W'(mask_words[b]);
                    end
                end
                RGN_PEND: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (acc.bank == BANK_IDX_W'(b)) rd_next = DATA_W'(pend_words[b]);
                    end
                end
                default: rd_next = DATA_W'(svc);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gint_ctrl_chk.sv
module gint_ctrl_chk
    import gint_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      irq_out,
    input logic [NUM_BANKS*PINS-1:0] pend_all,
    input logic [NUM_BANKS*PINS-1:0] mask_all,
    input logic [SVC_FIELD_W-1:0]    svc_group,
    input logic [SVC_FIELD_W-1:0]    svc_pin
);

    logic [NUM_BANKS*PINS-1:0] eff_c;
    logic                      sel_bit;

    always_comb begin
        eff_c   = pend_all & ~mask_all;
        sel_bit = 1'b0;
        if (svc_group != '0 && int'(svc_group) <= NUM_BANKS && int'(svc_pin) < PINS) begin
            sel_bit = eff_c[(int'(svc_group) - 1) * PINS + int'(svc_pin)];
        end
    end

    AST_IRQ_MATCHES_SVC: assert property (@(posedge clk) disable iff (rst)
        irq_out == (svc_group != '0)); // R9

    AST_SVC_GROUP_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(svc_group) <= NUM_BANKS); // R7

    AST_SVC_PIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(svc_pin) < PINS); // R7

    AST_SVC_SELECTS_LIVE_PIN: assert property (@(posedge clk) disable iff (rst)
        (svc_group != '0) |-> sel_bit); // R8

    AST_ALL_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (&mask_all) |-> !irq_out); // R3

    AST_PEND_CLEARS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr) |=> ((pend_all & $past(pend_all)) == $past(pend_all))); // R4

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_wr) |=> (bus_rdata == '0)); // R11

endmodule

bind gint_ctrl gint_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend_all  (pend_all),
    .mask_all  (mask_all),
    .svc_group (svc_group),
    .svc_pin   (svc_pin)
);

// File: tb/gint_ctrl_tb.sv
`timescale 1ns/1ps
module gint_ctrl_tb_top;

    localparam int NB    = 4;
    localparam int NP    = 8;
    localparam int TOTAL = NB * NP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [TOTAL-1:0] pins = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string cur_tag = "R11";

    always #10 clk = ~clk;

    gint_ctrl #(.NUM_BANKS(NB), .PINS(NP)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pins),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_out   (irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_cfg [TOTAL];
    bit [31:0]   m_mask, m_pend, m_s1, m_s2, m_prev;
    bit [31:0]   m_exp_rd;
    string       m_rd_tag = "R11";

    function automatic bit m_fire(int code, bit cur, bit prv);
        if (code == 0) return !cur;
        if (code == 1) return cur;
        if (code == 2) return prv && !cur;
        if (code == 3) return !prv && cur;
        if (code == 4) return prv != cur;
        return 1'b0;
    endfunction

    function automatic bit [31:0] m_service();
        bit [31:0] live = m_pend & ~m_mask;
        for (int i = 0; i < TOTAL; i++) begin
            if (live[i]) return ((i / NP + 1) << 8) | (i % NP);
        end
        return 0;
    endfunction

    function automatic bit [31:0] m_read(bit [5:0] a);
        int rg = a[5:4];
        int bk = a[3:0];
        bit [31:0] v = 0;
        if (rg == 3) return m_service();
        if (bk >= NB) return 0;
        if (rg == 0) begin
            for (int p = 0; p < NP; p++) v = v | (32'(m_cfg[bk*NP+p]) << (3*p));
        end else if (rg == 1) begin
            v = (m_mask >> (bk*NP)) & 32'hFF;
        end else begin
            v = (m_pend >> (bk*NP)) & 32'hFF;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        bit [31:0] fire;
        bit [31:0] clr;
        int rg;
        int bk;
        if (rst) begin
            for (int i = 0; i < TOTAL; i++) m_cfg[i] = 7;
            m_mask = '1; m_pend = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_exp_rd = 0; m_rd_tag = "R10";
        end else begin
            m_rd_tag = cur_tag;
            m_exp_rd = (sel && !wr) ? m_read(addr) : 32'h0;
            rg = addr[5:4];
            bk = addr[3:0];
            fire = 0;
            for (int i = 0; i < TOTAL; i++) fire[i] = m_fire(m_cfg[i], m_s2[i], m_prev[i]);
            clr = 0;
            if (sel && wr && rg == 2 && bk < NB) clr = (wdata & 32'hFF) << (bk*NP);
            m_pend = fire | (m_pend & ~clr);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
            if (sel && wr && bk < NB) begin
                if (rg == 0) for (int p = 0; p < NP; p++) m_cfg[bk*NP+p] = int'((wdata >> (3*p)) & 7);
                if (rg == 1) begin
                    for (int p = 0; p < NP; p++) m_mask[bk*NP+p] = wdata[p];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            checks++;
            if (irq !== ((m_pend & ~m_mask) != 0)) begin
                errors++;
                $display("FAIL R9 irq_out per-cycle: actual=%0b expected=%0b", irq, (m_pend & ~m_mask) != 0);
            end
            checks++;
            if (rdata !== m_exp_rd) begin
                errors++;
                $display("FAIL %s read data per-cycle: actual=%h expected=%h", m_rd_tag, rdata, m_exp_rd);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic bus_write(input bit [5:0] a, input bit [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic expect_rd(input bit [5:0] a, input bit [31:0] exp, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; cur_tag = tag;
        @(negedge clk);
        sel = 1'b0; cur_tag = "R11";
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, a, rdata, exp);
        end
    endtask

    task automatic expect_irq(input bit exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq_out: actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic set_pin(input int idx, input bit v, input int settle);
        @(negedge clk);
        pins[idx] = v;
        repeat (settle) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R10 reset state
        expect_irq(1'b0, "R10");
        expect_rd(6'd0,  32'h00FF_FFFF, "R10");
        expect_rd(6'd16, 32'h0000_00FF, "R10");
        expect_rd(6'd32, 32'h0, "R10");
        expect_rd(6'd48, 32'h0, "R7");

        // R1 / R2 field placement: bank 1 pin 3 rising
        bus_write(6'd1, 32'h00FF_F7FF);
        expect_rd(6'd1, 32'h00FF_F7FF, "R1");
        set_pin(11, 1'b1, 5);
        expect_rd(6'd33, 32'h08, "R5");
        expect_irq(1'b0, "R3");
        expect_rd(6'd48, 32'h0, "R3");
        bus_write(6'd33, 32'h00);
        expect_rd(6'd33, 32'h08, "R4");
        bus_write(6'd17, 32'hF7);
        expect_irq(1'b1, "R9");
        expect_rd(6'd48, 32'h0203, "R7");
        bus_write(6'd33, 32'h08);
        repeat (5) @(negedge clk);
        expect_rd(6'd33, 32'h0, "R5");
        expect_irq(1'b0, "R9");

        // R6 level high on bank 0 pin 5, R8 bank priority
        bus_write(6'd0, 32'h00FC_FFFF);
        bus_write(6'd16, 32'hDF);
        set_pin(11, 1'b0, 4);
        set_pin(11, 1'b1, 0);
        set_pin(5, 1'b1, 5);
        expect_rd(6'd48, 32'h0105, "R8");
        expect_rd(6'd33, 32'h08, "R5");
        bus_write(6'd32, 32'h20);
        expect_rd(6'd32, 32'h20, "R6");
        set_pin(5, 1'b0, 4);
        bus_write(6'd32, 32'h20);
        expect_rd(6'd32, 32'h0, "R6");
        expect_rd(6'd48, 32'h0203, "R8");

        // R8 pin priority inside bank 1 with level low on pin 6
        bus_write(6'd1, 32'h00E3_F7FF);
        bus_write(6'd17, 32'hB7);
        repeat (5) @(negedge clk);
        expect_rd(6'd33, 32'h48, "R1");
        expect_rd(6'd48, 32'h0203, "R8");
        bus_write(6'd33, 32'h08);
        expect_rd(6'd48, 32'h0206, "R8");
        set_pin(14, 1'b1, 4);
        bus_write(6'd33, 32'h40);
        expect_rd(6'd33, 32'h0, "R4");

        // R1 falling and both edges on bank 2, pending while masked (R3)
        bus_write(6'd2, 32'h00FF_FFE2);
        set_pin(16, 1'b1, 5);
        expect_rd(6'd34, 32'h0, "R1");
        set_pin(16, 1'b0, 5);
        expect_rd(6'd34, 32'h01, "R1");
        set_pin(17, 1'b1, 5);
        expect_rd(6'd34, 32'h03, "R1");
        expect_irq(1'b0, "R3");
        bus_write(6'd34, 32'h02);
        set_pin(17, 1'b0, 5);
        expect_rd(6'd34, 32'h03, "R1");
        bus_write(6'd34, 32'h03);
        expect_rd(6'd34, 32'h0, "R4");

        // R1 disabled code 6 on bank 3 pin 0
        bus_write(6'd3, 32'h00FF_FFFE);
        bus_write(6'd19, 32'hFE);
        set_pin(24, 1'b1, 4);
        set_pin(24, 1'b0, 4);
        expect_rd(6'd35, 32'h0, "R1");
        expect_irq(1'b0, "R1");

        // R11 service write ignored, R2 out-of-range bank reads zero
        bus_write(6'd48, 32'hFFFF_FFFF);
        expect_rd(6'd48, 32'h0, "R11");
        expect_rd(6'd4, 32'h0, "R2");
        expect_rd(6'd20, 32'h0, "R2");

        // R10 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_rd(6'd1, 32'h00FF_FFFF, "R10");
        expect_rd(6'd17, 32'hFF, "R10");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule